// File: doc/BRIEF.md
# Interrupt and Stack Sequencer

This block runs the stack traffic of a small 8-bit processor. It owns the 8-bit stack pointer and the status byte. It takes one command at a time from the instruction decoder: subroutine call, subroutine return, return from interrupt, software break, and push or pull of the accumulator or the status byte. It also latches the non-maskable and maskable interrupt requests and services a pending one before it accepts the next command. It moves one byte per cycle over a byte-wide memory port.

The stack sits in page one and grows downward. A push writes at the current pointer and then decrements it. A pull increments the pointer and then reads. Control transfers end with a one-cycle `pc_load` strobe carrying the new program counter. The decoder may issue a command whenever `busy` is low. Requests that arrive while `busy` is high are held.

Top module: `stack_seq`

## Requirements
- R1: After `rst_n` is released the stack pointer is 0xFD and the status is 0x34. The block reads 0xFFFC and then 0xFFFD, and pulses `pc_load` with {byte at 0xFFFD, byte at 0xFFFC}. No write happens and `busy` is high until that pulse.
- R2: A push writes at address 0x0100 OR pointer and then decrements the pointer. A pull increments the pointer and then reads 0x0100 OR the new pointer. Both wrap modulo 256 (0x00 pulled past 0xFF, 0xFF pushed below 0x00). Each cycle carries at most one access.
- R3: Interrupt entry writes `pc_in` high byte, then its low byte, then status, at descending stack addresses. It then reads the vector low and high bytes and sets status bit 2 (interrupt disable). `busy` is high for exactly 8 cycles after the requesting cycle: one to take the request and seven for the sequence.
- R4: The non-maskable vector is read at 0xFFFA/0xFFFB. The maskable interrupt and the break both use 0xFFFE/0xFFFF.
- R5: Break (command code 3) sets status bit 4 before it pushes status, and sets bit 2 after the push. A hardware interrupt pushes the status unchanged.
- R6: Call (code 0) pushes `pc_in`−1, high byte first, and then loads `tgt_in` into the program counter.
- R7: Return (code 1) pulls the low byte and then the high byte, and loads that address plus one.
- R8: Return from interrupt (code 2) pulls the status, then the low byte, then the high byte, and loads the address without adding one.
- R9: Codes 4 and 5 push `a_in` and the status. Codes 6 and 7 pull into `a_out` (with an `a_load` pulse) or into the status. A pull into `a_out` sets status bit 1 when the byte is zero and copies its bit 7 into status bit 7.
- R10: A maskable request is latched only when status bit 2 is clear in the requesting cycle. Otherwise it has no effect: `busy` stays low and the pointer does not change.
- R11: One request slot is kept. A non-maskable request replaces a latched maskable one. A maskable request never replaces a latched non-maskable one, and that maskable request is dropped. A request that arrives while `busy` is high is kept and serviced before the next command.
- R12: A `rst_req` pulse subtracts 3 from the pointer without writing, sets status bit 2, drops any latched request, and fetches the 0xFFFC vector as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| rst_req | input | 1 | Warm reset pulse |
| nmi_req | input | 1 | Non-maskable interrupt request pulse |
| irq_req | input | 1 | Maskable interrupt request |
| cmd_valid | input | 1 | Command strobe, honoured while busy is low |
| cmd_op | input | 3 | Command code (0 call … 7 pull status) |
| pc_in | input | 16 | Address of the next instruction |
| tgt_in | input | 16 | Call target |
| a_in | input | 8 | Accumulator value to push |
| mem_rdata | input | 8 | Read data, valid in the cycle of the read |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Sequence running or request latched |
| pc_load | output | 1 | One-cycle strobe for a new program counter |
| pc_out | output | 16 | New program counter |
| a_load | output | 1 | One-cycle strobe for a pulled accumulator |
| a_out | output | 8 | Pulled accumulator value |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status byte |

## Verification
The embedded properties check every cycle that writes stay in page one and never coincide with a read. They also check that each stack access moves the pointer by one in the right direction, that a latched non-maskable request stays latched until it is taken, that a masked maskable request latches nothing, and that every interrupt entry ends with interrupt disable set and a program-counter load. The byte order of each push and pull sequence, the vectors, the return-address arithmetic, the 8-cycle busy window and the priority outcome of two overlapping requests depend on history. Only the bench's scoreboard scenarios show these.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_POWERUP = 8'hFD,
  parameter logic [7:0]  P_POWERUP  = 8'h34,
  parameter logic [15:0] NMI_VEC    = 16'hFFFA,
  parameter logic [15:0] RST_VEC    = 16'hFFFC,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_req,
  input  logic        nmi_req,
  input  logic        irq_req,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [15:0] pc_in,
  input  logic [15:0] tgt_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [7:0]  mem_wdata,
  output logic        busy,
  output logic        pc_load,
  output logic [15:0] pc_out,
  output logic        a_load,
  output logic [7:0]  a_out,
  output logic [7:0]  sp,
  output logic [7:0]  status
);
  localparam int ZF = 1;
  localparam int IF = 2;
  localparam int BF = 4;
  localparam int NF = 7;

  typedef enum logic [3:0] {S_IDLE, S_RST, S_INT, S_CALL, S_RET, S_RTI,
                            S_PHA, S_PHP, S_PLA, S_PLP} seq_t;
  typedef enum logic [1:0] {P_NONE, P_IRQ, P_NMI} pend_t;

  seq_t        seq;
  pend_t       pend, pend_d;
  logic [2:0]  step;
  logic [7:0]  sp_q, p_q, lo_q, a_q;
  logic [15:0] pc_q, tgt_q, vec_q;
  logic        brk_q;
  logic        push, pull, last;

  wire idle     = (seq == S_IDLE);
  wire take_int = idle && (pend != P_NONE);
  wire take_cmd = idle && (pend == P_NONE) && cmd_valid;

  wire [15:0] ret_addr = pc_q - 16'd1;
  wire [7:0]  p_stk    = brk_q ? (p_q | 8'h10) : p_q;

  assign busy   = !idle || (pend != P_NONE);
  assign sp     = sp_q;
  assign status = p_q;

  always_comb begin
    pend_d = take_int ? P_NONE : pend;
    if (nmi_req) pend_d = P_NMI;
    else if (irq_req && !p_q[IF] && pend_d != P_NMI) pend_d = P_IRQ;
  end

  always_comb begin
    push = 1'b0;
    pull = 1'b0;
    last = 1'b0;
    mem_re = 1'b0;
    mem_wdata = 8'h00;
    mem_addr = 16'h0000;
    case (seq)
      S_RST: begin
        mem_re = 1'b1;
        mem_addr = vec_q + {15'd0, step[0]};
        last = (step == 3'd1);
      end
      S_INT: begin
        case (step)
          3'd2: begin push = 1'b1; mem_wdata = pc_q[15:8]; end
          3'd3: begin push = 1'b1; mem_wdata = pc_q[7:0]; end
          3'd4: begin push = 1'b1; mem_wdata = p_stk; end
          3'd5: begin mem_re = 1'b1; mem_addr = vec_q; end
          3'd6: begin mem_re = 1'b1; mem_addr = vec_q + 16'd1; last = 1'b1; end
          default: ;
        endcase
      end
      S_CALL: begin
        push = 1'b1;
        mem_wdata = (step == 3'd0) ? ret_addr[15:8] : ret_addr[7:0];
        last = (step == 3'd1);
      end
      S_RET: begin pull = 1'b1; last = (step == 3'd1); end
      S_RTI: begin pull = 1'b1; last = (step == 3'd2); end
      S_PHA: begin push = 1'b1; mem_wdata = a_q; last = 1'b1; end
      S_PHP: begin push = 1'b1; mem_wdata = p_q; last = 1'b1; end
      S_PLA, S_PLP: begin pull = 1'b1; last = 1'b1; end
      default: ;
    endcase
    if (push) mem_addr = {STACK_PAGE, sp_q};
    if (pull) begin
      mem_re = 1'b1;
      mem_addr = {STACK_PAGE, sp_q + 8'd1};
    end
  end

  assign mem_we = push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq <= S_RST;
      step <= 3'd0;
      pend <= P_NONE;
      sp_q <= SP_POWERUP;
      p_q <= P_POWERUP;
      vec_q <= RST_VEC;
      lo_q <= 8'h00;
      a_q <= 8'h00;
      pc_q <= 16'h0000;
      tgt_q <= 16'h0000;
      brk_q <= 1'b0;
      pc_load <= 1'b0;
      pc_out <= 16'h0000;
      a_load <= 1'b0;
      a_out <= 8'h00;
    end else begin
      pc_load <= 1'b0;
      a_load <= 1'b0;
      if (rst_req) begin
        seq <= S_RST;
        step <= 3'd0;
        vec_q <= RST_VEC;
        pend <= P_NONE;
        sp_q <= sp_q - 8'd3;
        p_q[IF] <= 1'b1;
      end else begin
        pend <= pend_d;
        if (take_int) begin
          seq <= S_INT;
          step <= 3'd0;
          vec_q <= (pend == P_NMI) ? NMI_VEC : IRQ_VEC;
          brk_q <= 1'b0;
          pc_q <= pc_in;
        end else if (take_cmd) begin
          step <= 3'd0;
          pc_q <= pc_in;
          tgt_q <= tgt_in;
          a_q <= a_in;
          vec_q <= IRQ_VEC;
          brk_q <= (cmd_op == 3'd3);
          case (cmd_op)
            3'd0: seq <= S_CALL;
            3'd1: seq <= S_RET;
            3'd2: seq <= S_RTI;
            3'd3: seq <= S_INT;
            3'd4: seq <= S_PHA;
            3'd5: seq <= S_PHP;
            3'd6: seq <= S_PLA;
            default: seq <= S_PLP;
          endcase
        end else if (!idle) begin
          step <= step + 3'd1;
          if (last) seq <= S_IDLE;
          if (push) sp_q <= sp_q - 8'd1;
          if (pull) sp_q <= sp_q + 8'd1;
          case (seq)
            S_RST: begin
              if (step == 3'd0) lo_q <= mem_rdata;
              else begin pc_out <= {mem_rdata, lo_q}; pc_load <= 1'b1; end
            end
            S_INT: begin
              if (step == 3'd4) p_q <= p_stk | 8'h04;
              if (step == 3'd5) lo_q <= mem_rdata;
              if (step == 3'd6) begin pc_out <= {mem_rdata, lo_q}; pc_load <= 1'b1; end
            end
            S_CALL: if (last) begin pc_out <= tgt_q; pc_load <= 1'b1; end
            S_RET: begin
              if (step == 3'd0) lo_q <= mem_rdata;
              else begin pc_out <= {mem_rdata, lo_q} + 16'd1; pc_load <= 1'b1; end
            end
            S_RTI: begin
              if (step == 3'd0) p_q <= mem_rdata;
              if (step == 3'd1) lo_q <= mem_rdata;
              if (step == 3'd2) begin pc_out <= {mem_rdata, lo_q}; pc_load <= 1'b1; end
            end
            S_PLA: begin
              a_out <= mem_rdata;
              a_load <= 1'b1;
              p_q[ZF] <= (mem_rdata == 8'h00);
              p_q[NF] <= mem_rdata[7];
            end
            S_PLP: p_q <= mem_rdata;
            default: ;
          endcase
        end
      end
    end
  end

  a_r2_write_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == STACK_PAGE);
  a_r2_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !rst_req) |=> sp_q == $past(sp_q) - 8'd1);
  a_r2_pull_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && mem_addr[15:8] == STACK_PAGE && !rst_req) |=> sp_q == $past(sp_q) + 8'd1);
  a_r3_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == S_INT && step == 3'd6 && !rst_req) |=> (p_q[IF] && pc_load));
  a_r11_nmi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == P_NMI && !take_int && !rst_req) |=> pend == P_NMI);
  a_r10_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == P_NONE && p_q[IF] && !nmi_req && !rst_req) |=> pend == P_NONE);
  a_r5_brk_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == S_INT && step == 3'd4 && brk_q) |-> mem_wdata[BF]);
endmodule

// File: tb/test_stack_seq.sv
module test_stack_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  req;
  } ev_t;

  logic clk = 1'b0, rst_n = 1'b0, rst_req = 1'b0, nmi_req = 1'b0, irq_req = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [15:0] pc_in = 16'h0000, tgt_in = 16'h0000;
  logic [7:0] a_in = 8'h00;
  logic [7:0] mem_rdata, mem_wdata, a_out, sp, status;
  logic [15:0] mem_addr, pc_out;
  logic mem_we, mem_re, busy, pc_load, a_load;

  logic [7:0] stk [0:255];
  logic [7:0] vtab [0:5];
  logic [7:0] stk_m [0:255];
  logic [7:0] sp_m, p_m;
  ev_t q[$];
  int checks = 0, fails = 0, mchecks = 0, mfails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_seq i_stack_seq (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req), .irq_req(irq_req),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .pc_in(pc_in), .tgt_in(tgt_in), .a_in(a_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .busy(busy), .pc_load(pc_load), .pc_out(pc_out),
    .a_load(a_load), .a_out(a_out), .sp(sp), .status(status));

  assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] :
                     (mem_addr >= 16'hFFFA) ? vtab[mem_addr - 16'hFFFA] : 8'h00;

  always @(posedge clk)
    if (!rst_n) for (int i = 0; i < 256; i++) stk[i] <= 8'h00;
    else if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

  task automatic see(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
    ev_t e;
    mchecks++;
    if (q.size() == 0) begin
      mfails++;
      $display("FAIL unexpected event kind=%0d addr=%h data=%h (expected none)", k, a, d);
    end else begin
      e = q.pop_front();
      if (e.kind != k || e.addr != a || e.data != d) begin
        mfails++;
        $display("FAIL R%0d event actual kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
                 e.req, k, a, d, e.kind, e.addr, e.data);
      end
    end
  endtask

  always @(negedge clk)
    if (rst_n) begin
      if (mem_we || mem_re) see(mem_we ? 2'd0 : 2'd1, mem_addr, mem_we ? mem_wdata : 8'h00);
      if (pc_load) see(2'd2, pc_out, 8'h00);
      if (a_load) see(2'd3, 16'h0000, a_out);
    end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic ev_t mk(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d, input int r);
    return '{kind: k, addr: a, data: d, req: 8'(r)};
  endfunction

  task automatic m_push(input logic [7:0] d, input int r);
    q.push_back(mk(2'd0, {8'h01, sp_m}, d, r));
    stk_m[sp_m] = d;
    sp_m = sp_m - 8'd1;
  endtask

  task automatic m_pull(output logic [7:0] d, input int r);
    sp_m = sp_m + 8'd1;
    q.push_back(mk(2'd1, {8'h01, sp_m}, 8'h00, r));
    d = stk_m[sp_m];
  endtask

  task automatic m_vec(input logic [15:0] v, input int r);
    q.push_back(mk(2'd1, v, 8'h00, r));
    q.push_back(mk(2'd1, v + 16'd1, 8'h00, r));
    q.push_back(mk(2'd2, {vtab[v - 16'hFFFA + 16'd1], vtab[v - 16'hFFFA]}, 8'h00, r));
  endtask

  task automatic m_int(input logic [15:0] v, input logic [15:0] pc, input bit brk);
    m_push(pc[15:8], 3);
    m_push(pc[7:0], 3);
    if (brk) p_m = p_m | 8'h10;
    m_push(p_m, 5);
    p_m = p_m | 8'h04;
    m_vec(v, 4);
  endtask

  task automatic m_rti(input logic [15:0] pc);
    logic [7:0] lo, hi;
    m_pull(p_m, 8);
    m_pull(lo, 8);
    m_pull(hi, 8);
    q.push_back(mk(2'd2, {hi, lo}, 8'h00, 8));
  endtask

  task automatic m_ret;
    logic [7:0] lo, hi;
    m_pull(lo, 7);
    m_pull(hi, 7);
    q.push_back(mk(2'd2, {hi, lo} + 16'd1, 8'h00, 7));
  endtask

  task automatic m_call(input logic [15:0] pc, input logic [15:0] tgt);
    m_push(8'((pc - 16'd1) >> 8), 6);
    m_push(8'(pc - 16'd1), 6);
    q.push_back(mk(2'd2, tgt, 8'h00, 6));
  endtask

  task automatic m_pla;
    logic [7:0] d;
    m_pull(d, 9);
    q.push_back(mk(2'd3, 16'h0000, d, 9));
    p_m[1] = (d == 8'h00);
    p_m[7] = d[7];
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] pc, input logic [15:0] tgt, input logic [7:0] a);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; pc_in = pc; tgt_in = tgt; a_in = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", (checks + mchecks) - (fails + mfails), checks + mchecks);
    $finish;
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int n;
    logic [7:0] d;
    vtab[0] = 8'h34; vtab[1] = 8'h12; vtab[2] = 8'h00;
    vtab[3] = 8'h80; vtab[4] = 8'h78; vtab[5] = 8'h56;
    for (int i = 0; i < 256; i++) stk_m[i] = 8'h00;
    sp_m = 8'hFD; p_m = 8'h34;
    m_vec(16'hFFFC, 1);
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4) rst_n = 1'b1;
    wait_idle();
    chk(sp == 8'hFD, "R1 sp", 16'(sp), 16'h00FD);
    chk(status == 8'h34, "R1 status", 16'(status), 16'h0034);

    // R10: masked request has no effect
    irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy, "R10 busy after masked irq", 16'(busy), 16'h0000);
    chk(sp == sp_m, "R10 sp after masked irq", 16'(sp), 16'(sp_m));

    // R9: push/pull accumulator and status
    m_push(8'h00, 9); issue(3'd4, 16'h0, 16'h0, 8'h00);
    m_pull(d, 9); p_m = d; issue(3'd7, 16'h0, 16'h0, 8'h00);
    wait_idle();
    chk(status == 8'h00, "R9 status pulled", 16'(status), 16'h0000);
    m_push(8'h80, 9); issue(3'd4, 16'h0, 16'h0, 8'h80);
    m_pla(); issue(3'd6, 16'h0, 16'h0, 8'h00);
    wait_idle();
    chk(status == 8'h80, "R9 negative flag", 16'(status), 16'h0080);
    m_push(8'h00, 9); issue(3'd4, 16'h0, 16'h0, 8'h00);
    m_pla(); issue(3'd6, 16'h0, 16'h0, 8'h00);
    wait_idle();
    chk(status == 8'h02, "R9 zero flag", 16'(status), 16'h0002);

    // R6 call then R7 return
    m_call(16'h1003, 16'h2000); issue(3'd0, 16'h1003, 16'h2000, 8'h00);
    m_ret(); issue(3'd1, 16'h0, 16'h0, 8'h00);
    wait_idle();
    chk(sp == 8'hFD, "R7 sp after return", 16'(sp), 16'h00FD);

    // R3 R4 maskable interrupt entry
    pc_in = 16'h4321;
    m_int(16'hFFFE, 16'h4321, 1'b0);
    irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == 8, "R3 busy cycles", 16'(n), 16'd8);
    chk(sp == 8'hFA, "R3 sp after entry", 16'(sp), 16'h00FA);
    chk(status == 8'h06, "R3 interrupt disable set", 16'(status), 16'h0006);

    // R8 return from interrupt
    m_rti(16'h4321); issue(3'd2, 16'h0, 16'h0, 8'h00);
    wait_idle();
    chk(status == 8'h02, "R8 status restored", 16'(status), 16'h0002);
    chk(sp == 8'hFD, "R8 sp", 16'(sp), 16'h00FD);

    // R11: irq then nmi while busy, nmi displaces irq
    m_call(16'h3001, 16'h6000);
    m_int(16'hFFFA, 16'h3001, 1'b0);
    issue(3'd0, 16'h3001, 16'h6000, 8'h00);
    irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
    nmi_req = 1'b1; @(negedge clk); nmi_req = 1'b0;
    wait_idle();
    chk(status == 8'h06, "R11 nmi taken", 16'(status), 16'h0006);
    m_rti(16'h3001); issue(3'd2, 16'h0, 16'h0, 8'h00);
    m_ret(); issue(3'd1, 16'h0, 16'h0, 8'h00);
    wait_idle();

    // R11: nmi then irq while busy, irq never displaces nmi
    m_call(16'h3101, 16'h6100);
    m_int(16'hFFFA, 16'h3101, 1'b0);
    issue(3'd0, 16'h3101, 16'h6100, 8'h00);
    nmi_req = 1'b1; @(negedge clk); nmi_req = 1'b0;
    irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
    wait_idle();
    chk(sp == 8'hF8, "R11 sp after nmi", 16'(sp), 16'h00F8);
    m_rti(16'h3101); issue(3'd2, 16'h0, 16'h0, 8'h00);
    m_ret(); issue(3'd1, 16'h0, 16'h0, 8'h00);
    wait_idle();

    // R5 break
    m_int(16'hFFFE, 16'h0202, 1'b1); issue(3'd3, 16'h0202, 16'h0, 8'h00);
    wait_idle();
    chk(status == 8'h16, "R5 break flags", 16'(status), 16'h0016);
    irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy, "R10 irq masked after break", 16'(busy), 16'h0000);
    m_rti(16'h0202); issue(3'd2, 16'h0, 16'h0, 8'h00);
    wait_idle();
    chk(status == 8'h12, "R8 status after break return", 16'(status), 16'h0012);

    // R2 wrap on pull and push
    m_pla(); issue(3'd6, 16'h0, 16'h0, 8'h00);
    m_pla(); issue(3'd6, 16'h0, 16'h0, 8'h00);
    m_pla(); issue(3'd6, 16'h0, 16'h0, 8'h00);
    wait_idle();
    chk(sp == 8'h00, "R2 pointer wrapped up", 16'(sp), 16'h0000);
    m_push(8'hA5, 2); issue(3'd4, 16'h0, 16'h0, 8'hA5);
    m_push(8'h3C, 2); issue(3'd4, 16'h0, 16'h0, 8'h3C);
    m_push(p_m, 2); issue(3'd5, 16'h0, 16'h0, 8'h00);
    wait_idle();
    chk(sp == 8'hFD, "R2 pointer wrapped down", 16'(sp), 16'h00FD);

    // R12 warm reset
    m_vec(16'hFFFC, 12);
    sp_m = sp_m - 8'd3; p_m = p_m | 8'h04;
    @(negedge clk);
    rst_req = 1'b1; @(negedge clk); rst_req = 1'b0;
    wait_idle();
    chk(sp == 8'hFA, "R12 sp minus three", 16'(sp), 16'h00FA);
    chk(status == p_m, "R12 interrupt disable", 16'(status), 16'(p_m));

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R1 all expected events seen", 16'(q.size()), 16'h0000);
    summary();
  end
endmodule